// File: doc/BRIEF.md
# BCD Calendar Time Counter

This block keeps a 24-hour calendar clock in packed BCD: seconds, minutes, hours, a weekday index, day of month, month and a two-digit year. A prescaler counts the cycles on which the clock-enable input is high, normally driven at 32768 Hz. Every `PRESCALE` such cycles it produces a one-second tick. Each tick advances the time, and every field rolls over and carries into the next.

A host sees eight 16-bit registers. Indices 0 to 6 hold seconds, minutes, hours, weekday, day, month and year. Index 7 is the load strobe. Host writes to indices 0 to 6 only fill a staging copy. The staged values move into the running time in one step, when index 7 is written with bit 15 set. That same load restarts the prescaler, so a full second always follows a load. Bit 15 of the year register is a leap flag that the host supplies. The hardware never computes it, and it decides whether February has 28 or 29 days. Reads on indices 0 to 6 always show the running time.

Top module: `cal_time_keeper`

## Requirements
- R1: After a synchronous active-low reset the running time reads seconds 00, minutes 00, hours 00, weekday 0, day 01, month 01, year 00, leap flag 0. The staging copy holds the same values.
- R2: A write to indices 0 to 6 changes only the staging copy. Readback of the running time is unchanged until a load.
- R3: A write of index 7 with bit 15 = 1 copies all seven staged registers into the running time at that clock edge. If bit 15 = 0, the write has no effect. Index 7 always reads 0x0000.
- R4: Significant bits per index are 0:[6:0], 1:[6:0], 2:[5:0], 3:[2:0], 4:[5:0], 5:[4:0] and 6:[7:0], plus the leap flag at bit 15 of index 6. All other bits are dropped on write and read as 0.
- R5: A one-second tick occurs on the `PRESCALE`-th cycle that has `tick_en` high. Cycles with `tick_en` low do not count. A load restarts the count from zero.
- R6: Seconds and minutes roll from 59 to 00 and carry. Hours roll from 23 to 00 and carry into both weekday and day. A field at or above its limit wraps on its next advance.
- R7: Weekday counts 0 to 6 and wraps from 6 to 0 on a day carry.
- R8: Day of month wraps to 01 after 30 for months 04, 06, 09 and 11, after 31 for the other months, and after 28 for month 02, or after 29 when the leap flag is 1.
- R9: Month rolls from 12 to 01 and carries into year. Year rolls from 99 to 00. Counting never changes the leap flag.
- R10: When a load and a tick fall in the same cycle, the loaded values appear unincremented.
- R11: Readback of indices 0 to 6 is combinational from the running time, in BCD with the year's leap flag at bit 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Clock-enable pulse at the prescaler reference rate |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 3 | Host write register index |
| wr_data | input | 16 | Host write data |
| rd_addr | input | 3 | Host read register index |
| rd_data | output | 16 | Readback of the running time, or 0 for index 7 |

## Verification
A load and a second tick can land on the same clock edge. There the load has to win, and the prescaler has to restart. The bench counts enables so that the load strobe and the final enable of a second share one cycle. It then expects the staged seconds exactly, with no increment. After that it expects the value to hold through `PRESCALE`-1 more enables and to step on the next one.

// File: rtl/cal_pkg.sv
// Shared types and helpers for the BCD calendar time counter.
// Assumes all time fields are held as packed BCD digits.
package cal_pkg;

    localparam int NUM_REGS = 8;
    localparam int IDX_W    = $clog2(NUM_REGS);
    localparam logic [IDX_W-1:0] IDX_SEC  = 3'd0;
    localparam logic [IDX_W-1:0] IDX_MIN  = 3'd1;
    localparam logic [IDX_W-1:0] IDX_HOUR = 3'd2;
    localparam logic [IDX_W-1:0] IDX_WDAY = 3'd3;
    localparam logic [IDX_W-1:0] IDX_MDAY = 3'd4;
    localparam logic [IDX_W-1:0] IDX_MON  = 3'd5;
    localparam logic [IDX_W-1:0] IDX_YEAR = 3'd6;
    localparam logic [IDX_W-1:0] IDX_LOAD = 3'd7;
    localparam int LOAD_BIT = 15;

    typedef struct packed {
        logic [6:0] sec;
        logic [6:0] min;
        logic [5:0] hour;
        logic [2:0] wday;
        logic [5:0] mday;
        logic [4:0] mon;
        logic [7:0] year;
        logic       leap;
    } cal_time_t;

    // Significant bits of each time register
    function automatic logic [15:0] reg_mask(input int idx);
        case (idx)
            0, 1:    return 16'h007F;
            2, 4:    return 16'h003F;
            3:       return 16'h0007;
            5:       return 16'h001F;
            6:       return 16'h80FF;
            default: return 16'h0000;
        endcase
    endfunction

    // Reset contents of each time register
    function automatic logic [15:0] reg_init(input int idx);
        return (idx == 4 || idx == 5) ? 16'h0001 : 16'h0000;
    endfunction

    // Two-digit BCD increment without range wrap
    function automatic logic [7:0] bcd_inc8(input logic [7:0] v);
        if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
        else                return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // Last day of the given BCD month
    function automatic logic [5:0] month_len(input logic [4:0] m, input logic lp);
        case (m)
            5'h02:                      return lp ? 6'h29 : 6'h28;
            5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
            default:                    return 6'h31;
        endcase
    endfunction

endpackage

// File: rtl/cal_prescaler.sv
// Divides the reference enable down to a one-second tick.
// Assumes PRESCALE >= 2; restart forces the count back to zero.
module cal_prescaler #(
    parameter int PRESCALE = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    input  logic restart,
    output logic sec_tick
);
    localparam int CW = $clog2(PRESCALE);
    localparam logic [CW-1:0] LAST = CW'(PRESCALE - 1);

    logic [CW-1:0] cnt;

    assign sec_tick = tick_en && (cnt == LAST);

    // Count enable cycles, wrap at the last one, restart on load
    always_ff @(posedge clk) begin
        if (!rst_n || restart)  cnt <= '0;
        else if (sec_tick)      cnt <= '0;
        else if (tick_en)       cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/cal_shadow.sv
// Staging copy of the seven time registers, written by the host.
// Assumes writes to the load index are decoded elsewhere.
module cal_shadow
    import cal_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_addr,
    input  logic [15:0]      wr_data,
    output cal_time_t        staged
);
    logic [15:0] sh [NUM_REGS-1];

    for (genvar i = 0; i < NUM_REGS - 1; i++) begin : g_reg
        // Hold one masked staging register
        always_ff @(posedge clk) begin
            if (!rst_n)                                 sh[i] <= reg_init(i);
            else if (wr_en && wr_addr == IDX_W'(i))     sh[i] <= wr_data & reg_mask(i);
        end
    end

    // Unpack staging registers into the time record
    always_comb begin
        staged.sec  = sh[0][6:0];
        staged.min  = sh[1][6:0];
        staged.hour = sh[2][5:0];
        staged.wday = sh[3][2:0];
        staged.mday = sh[4][5:0];
        staged.mon  = sh[5][4:0];
        staged.year = sh[6][7:0];
        staged.leap = sh[6][15];
    end
endmodule

// File: rtl/cal_time_core.sv
// Running calendar time: loads the staged record or advances on a tick.
// Assumes a load takes priority over a simultaneous tick.
module cal_time_core
    import cal_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      load,
    input  logic      sec_tick,
    input  cal_time_t staged,
    output cal_time_t live
);
    cal_time_t nxt;
    logic c_sec, c_min, c_hour, c_day, c_mon;

    // Compute the time one second later with the carry chain
    always_comb begin
        nxt    = live;
        c_sec  = live.sec  >= 7'h59;
        c_min  = c_sec  && (live.min  >= 7'h59);
        c_hour = c_min  && (live.hour >= 6'h23);
        c_day  = c_hour && (live.mday >= month_len(live.mon, live.leap));
        c_mon  = c_day  && (live.mon  >= 5'h12);
        nxt.sec = c_sec ? 7'h00 : 7'(bcd_inc8({1'b0, live.sec}));
        if (c_sec)
            nxt.min = c_min ? 7'h00 : 7'(bcd_inc8({1'b0, live.min}));
        if (c_min)
            nxt.hour = c_hour ? 6'h00 : 6'(bcd_inc8({2'b0, live.hour}));
        if (c_hour) begin
            nxt.wday = (live.wday >= 3'd6) ? 3'd0 : live.wday + 3'd1;
            nxt.mday = c_day ? 6'h01 : 6'(bcd_inc8({2'b0, live.mday}));
        end
        if (c_day)
            nxt.mon = c_mon ? 5'h01 : 5'(bcd_inc8({3'b0, live.mon}));
        if (c_mon)
            nxt.year = (live.year >= 8'h99) ? 8'h00 : bcd_inc8(live.year);
    end

    // Update the running time: reset, load, or tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live      <= '0;
            live.mday <= 6'h01;
            live.mon  <= 5'h01;
        end
        else if (load)     live <= staged;
        else if (sec_tick) live <= nxt;
    end
endmodule

// File: rtl/cal_time_keeper.sv
// Top of the BCD calendar counter: host staging, load strobe, readback.
// Assumes 24-hour operation and a host-supplied leap flag.
module cal_time_keeper
    import cal_pkg::*;
#(
    parameter int PRESCALE = 32768
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_en,
    input  logic        wr_en,
    input  logic [2:0]  wr_addr,
    input  logic [15:0] wr_data,
    input  logic [2:0]  rd_addr,
    output logic [15:0] rd_data
);
    logic      load, sec_tick;
    cal_time_t staged, live;

    assign load = wr_en && (wr_addr == IDX_LOAD) && wr_data[LOAD_BIT];

    cal_prescaler #(.PRESCALE(PRESCALE)) u_presc (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .restart(load), .sec_tick(sec_tick)
    );

    cal_shadow u_shadow (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .staged(staged)
    );

    cal_time_core u_core (
        .clk(clk), .rst_n(rst_n), .load(load),
        .sec_tick(sec_tick), .staged(staged), .live(live)
    );

    // Select the running-time field for the host read index
    always_comb begin
        case (rd_addr)
            IDX_SEC:  rd_data = {9'b0, live.sec};
            IDX_MIN:  rd_data = {9'b0, live.min};
            IDX_HOUR: rd_data = {10'b0, live.hour};
            IDX_WDAY: rd_data = {13'b0, live.wday};
            IDX_MDAY: rd_data = {10'b0, live.mday};
            IDX_MON:  rd_data = {11'b0, live.mon};
            IDX_YEAR: rd_data = {live.leap, 7'b0, live.year};
            default:  rd_data = 16'h0000;
        endcase
    end
endmodule

// File: rtl/cal_time_keeper_chk.sv
// Temporal checks on the calendar counter, bound to the top module.
module cal_time_keeper_chk
    import cal_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        load,
    input logic        sec_tick,
    input cal_time_t   staged,
    input cal_time_t   live,
    input logic [2:0]  rd_addr,
    input logic [15:0] rd_data
);
    // R3
    load_idx_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == IDX_LOAD) |-> (rd_data == 16'h0000));

    // R2
    idle_time_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !sec_tick) |=> $stable(live));

    // R10
    load_takes_staged_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (live == $past(staged)));

    // R6
    sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && !load && live.sec == 7'h59) |=> (live.sec == 7'h00));

    // R6
    min_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && !load && live.sec < 7'h59) |=> (live.min == $past(live.min)));

    // R9
    leap_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load) |=> (live.leap == $past(live.leap)));
endmodule

bind cal_time_keeper cal_time_keeper_chk u_chk (
    .clk(clk), .rst_n(rst_n), .load(load), .sec_tick(sec_tick),
    .staged(staged), .live(live), .rd_addr(rd_addr), .rd_data(rd_data)
);

// File: tb/cal_time_keeper_bench.sv
module cal_time_keeper_bench;
    localparam int PS = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [15:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int          q_addr [$];
    logic [15:0] q_exp  [$];
    int          q_req  [$];

    always #4 clk = ~clk;

    cal_time_keeper #(.PRESCALE(PS)) u_cal_time_keeper (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    // Monitor: pop expected items and compare away from the clock edge
    always @(posedge clk) begin
        #2;
        if (q_exp.size() > 0) begin
            int a, r;
            logic [15:0] e;
            a = q_addr.pop_front();
            e = q_exp.pop_front();
            r = q_req.pop_front();
            checks++;
            if (rd_data !== e) begin
                errors++;
                $display("FAIL R%0d idx %0d actual %h expected %h", r, a, rd_data, e);
            end
        end
    end

    task automatic expect_rd(input logic [2:0] a, input logic [15:0] e, input int r);
        @(negedge clk);
        rd_addr = a;
        q_addr.push_back(a); q_exp.push_back(e); q_req.push_back(r);
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic enables(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic load_time(input logic [15:0] s, m, h, w, d, mo, y);
        wr(0, s); wr(1, m); wr(2, h); wr(3, w); wr(4, d); wr(5, mo); wr(6, y);
        wr(7, 16'h8000);
    endtask

    task automatic expect_time(input logic [15:0] s, m, h, w, d, mo, y, input int r);
        expect_rd(0, s, r); expect_rd(1, m, r); expect_rd(2, h, r); expect_rd(3, w, r);
        expect_rd(4, d, r); expect_rd(5, mo, r); expect_rd(6, y, r);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        expect_time(16'h00, 16'h00, 16'h00, 16'h0, 16'h01, 16'h01, 16'h0000, 1);
        // R3: load index reads 0
        expect_rd(7, 16'h0000, 3);

        // R2: staged write invisible before load
        wr(0, 16'h0030);
        expect_rd(0, 16'h0000, 2);
        // R3: strobe with bit 15 clear has no effect
        wr(7, 16'h7FFF);
        expect_rd(0, 16'h0000, 3);
        wr(7, 16'h8000);
        expect_rd(0, 16'h0030, 3);

        // R4: masking of unused bits, leap flag kept
        load_time(16'hFFD5, 16'hFF59, 16'hFFD2, 16'hFFFB, 16'hFFD7, 16'hFFE9, 16'hFF24);
        expect_time(16'h55, 16'h59, 16'h12, 16'h3, 16'h17, 16'h09, 16'h8024, 4);

        // R5: only enabled cycles count toward a second
        load_time(16'h10, 16'h20, 16'h05, 16'h2, 16'h14, 16'h03, 16'h0033);
        repeat (PS - 1) begin enables(1); repeat (2) @(negedge clk); end
        expect_rd(0, 16'h10, 5);
        enables(1);
        expect_rd(0, 16'h11, 5);

        // R6: 59 s / 59 min carry into hour
        load_time(16'h59, 16'h59, 16'h09, 16'h1, 16'h14, 16'h03, 16'h0033);
        enables(PS);
        expect_time(16'h00, 16'h00, 16'h10, 16'h1, 16'h14, 16'h03, 16'h0033, 6);

        // R7 R8 R9: full year rollover, weekday 6 wraps, leap flag kept
        load_time(16'h59, 16'h59, 16'h23, 16'h6, 16'h31, 16'h12, 16'h8099);
        enables(PS);
        expect_time(16'h00, 16'h00, 16'h00, 16'h0, 16'h01, 16'h01, 16'h8000, 9);

        // R8: February without leap flag
        load_time(16'h59, 16'h59, 16'h23, 16'h3, 16'h28, 16'h02, 16'h0023);
        enables(PS);
        expect_rd(4, 16'h01, 8); expect_rd(5, 16'h03, 8); expect_rd(3, 16'h4, 7);
        // R8: February with leap flag, 28 -> 29 -> 01
        load_time(16'h59, 16'h59, 16'h23, 16'h3, 16'h28, 16'h02, 16'h8024);
        enables(PS);
        expect_rd(4, 16'h29, 8); expect_rd(5, 16'h02, 8);
        load_time(16'h59, 16'h59, 16'h23, 16'h3, 16'h29, 16'h02, 16'h8024);
        enables(PS);
        expect_rd(4, 16'h01, 8); expect_rd(5, 16'h03, 8);
        // R8: 30-day month, and BCD month 09 -> 10
        load_time(16'h59, 16'h59, 16'h23, 16'h0, 16'h30, 16'h09, 16'h0050);
        enables(PS);
        expect_rd(4, 16'h01, 8); expect_rd(5, 16'h10, 8);
        // R8: 31-day month does not wrap at 30
        load_time(16'h59, 16'h59, 16'h23, 16'h0, 16'h30, 16'h08, 16'h0050);
        enables(PS);
        expect_rd(4, 16'h31, 8); expect_rd(5, 16'h08, 8);

        // R10: load and tick in the same cycle
        load_time(16'h10, 16'h00, 16'h00, 16'h0, 16'h01, 16'h01, 16'h0000);
        wr(0, 16'h0040);
        enables(PS - 1);
        @(negedge clk);
        tick_en = 1'b1; wr_en = 1'b1; wr_addr = 3'd7; wr_data = 16'h8000;
        @(negedge clk);
        tick_en = 1'b0; wr_en = 1'b0;
        expect_rd(0, 16'h40, 10);
        // R5: prescaler restarted by the load
        enables(PS - 1);
        expect_rd(0, 16'h40, 5);
        enables(1);
        // R11: readback follows running time
        expect_rd(0, 16'h41, 11);

        repeat (4) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule